// File: doc/BRIEF.md
# Committed-Write Transmit Byte Queue

This block is the transmit-side byte store of a high-speed serial port. A host places outgoing bytes into a memory-mapped staging window, addressed relative to the current write position. None of those bytes reaches the transmitter yet. The host then writes a byte count, and that commit publishes the staged bytes in a single step. This lets software copy a whole burst before the transmitter can see any part of it.

A single readback word reports two values: the number of committed bytes not yet sent, and the byte write position. Software uses the low two bits of the position to align later copies to 32-bit words. A space-available flag tells the host when the queue has drained to a programmable level. An empty flag shows when nothing is left to send. The serial shifter sits outside the block and takes bytes through a valid/ready pop port.

Top module: `tx_window_fifo`

## Requirements
- R1: After reset, `ctrl_rd` reads 0, `tx_empty` and `space_avail` are 1, and `pop_valid` is 0.
- R2: Bytes written through the window are not visible to the pop port, and do not change the fill level, until a commit is written.
- R3: A commit of N bytes, within the free space, raises the fill level by N and advances the write position by N modulo 1024. Both values are visible on the cycle after the commit.
- R4: A window write at offset k stores its byte at write position + k (modulo 1024). Committed bytes leave in ascending offset order, whatever order they were written in.
- R5: Only 1020 bytes are usable. A commit count larger than 1020 minus the fill level is clamped to that difference, so the fill level never exceeds 1020.
- R6: A window write whose offset is at or above the free space (1020 minus the fill level) is dropped and leaves already committed bytes unchanged.
- R7: `ctrl_rd` bits 25:16 hold the fill level and bits 9:0 hold the write position; all other bits read 0.
- R8: `space_avail` is 1 exactly while the fill level is at or below 4 << `lvl`. For example, `lvl` = 5 gives 128 and `lvl` = 0 gives 4.
- R9: `tx_empty` is 1 exactly when the fill level is 0.
- R10: `pop_valid` is 1 whenever the fill level is non-zero, and `pop_data` shows the oldest committed byte. A cycle with both `pop_valid` and `pop_ready` high removes that byte and lowers the fill level by one.
- R11: A commit and a pop in the same cycle give a fill level of old + N − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_we | input | 1 | Window byte write strobe |
| win_off | input | 10 | Byte offset within the staging window |
| win_data | input | 8 | Byte to stage |
| commit_we | input | 1 | Commit strobe |
| commit_cnt | input | 10 | Number of staged bytes to publish |
| lvl | input | 3 | Space-available trigger code |
| ctrl_rd | output | 32 | Readback: fill level [25:16], write position [9:0] |
| space_avail | output | 1 | Fill level at or below trigger threshold |
| tx_empty | output | 1 | No committed bytes remain |
| pop_valid | output | 1 | A committed byte is available to the shifter |
| pop_ready | input | 1 | Shifter accepts the byte |
| pop_data | output | 8 | Oldest committed byte |

## Verification
The assertions check these on every cycle: the fill level never goes above 1020; the write position changes only on a commit; the fill level stays put when there is neither a commit nor a pop, and drops by exactly one on a pop alone; the unused readback bits stay zero; and an empty queue never offers a byte. Other behaviours need the bench's directed scenarios, because they depend on data values and stimulus history: the mapping of offset to location and the order of output, the dropping of writes that would hit unread data, clamping at capacity, the threshold across trigger codes, and the arithmetic when a commit and a pop fall in the same cycle.

// File: rtl/tx_window_fifo.sv
module tx_window_fifo #(
  parameter int AW     = 10,
  parameter int USABLE = 1020
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_we,
  input  logic [AW-1:0] win_off,
  input  logic [7:0]    win_data,
  input  logic          commit_we,
  input  logic [AW-1:0] commit_cnt,
  input  logic [2:0]    lvl,
  output logic [31:0]   ctrl_rd,
  output logic          space_avail,
  output logic          tx_empty,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [7:0]    pop_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr, fill;
  logic [AW-1:0] free_sp, n_eff;
  logic [AW:0]   thresh;
  logic          pop;

  assign free_sp = AW'(USABLE) - fill;
  assign n_eff   = (commit_cnt > free_sp) ? free_sp : commit_cnt;
  assign pop     = pop_valid && pop_ready;
  assign thresh  = (AW+1)'(4) << lvl;

  assign pop_valid   = (fill != '0);
  assign tx_empty    = (fill == '0);
  assign space_avail = ({1'b0, fill} <= thresh);
  assign pop_data    = mem[rptr];
  assign ctrl_rd     = (32'(fill) << 16) | 32'(wptr);

  always_ff @(posedge clk) begin
    if (win_we && (win_off < free_sp))
      mem[wptr + win_off] <= win_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (commit_we) wptr <= wptr + n_eff;
      if (pop) rptr <= rptr + 1'b1;
      fill <= fill + (commit_we ? n_eff : '0) - AW'(pop);
    end
  end
endmodule

// File: rtl/tx_window_fifo_chk.sv
module tx_window_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit_we,
  input logic [31:0] ctrl_rd,
  input logic        tx_empty,
  input logic        pop_valid,
  input logic        pop_ready
);
  // R5
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[25:16] <= 10'd1020);

  // R3
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_we |=> $stable(ctrl_rd[9:0]));

  // R2
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_we && !(pop_valid && pop_ready)) |=> $stable(ctrl_rd[25:16]));

  // R10
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_we && pop_valid && pop_ready) |=>
      ctrl_rd[25:16] == $past(ctrl_rd[25:16]) - 10'd1);

  // R7
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[31:26] == 6'd0 && ctrl_rd[15:10] == 6'd0);

  // R9
  empty_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> !pop_valid);
endmodule

bind tx_window_fifo tx_window_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit_we(commit_we), .ctrl_rd(ctrl_rd),
  .tx_empty(tx_empty), .pop_valid(pop_valid), .pop_ready(pop_ready)
);

// File: tb/tb_tx_window_fifo.sv
module tb_tx_window_fifo;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       win_we = 0;
  logic [9:0] win_off = 0;
  logic [7:0] win_data = 0;
  logic       commit_we = 0;
  logic [9:0] commit_cnt = 0;
  logic [2:0] lvl = 3'd5;
  logic [31:0] ctrl_rd;
  logic       space_avail, tx_empty, pop_valid, pop_ready = 0;
  logic [7:0] pop_data;

  int n_chk = 0, n_bad = 0;
  int wp = 0;

  always #2 clk = ~clk;

  tx_window_fifo dut (.*);

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int off, input int val);
    win_we = 1; win_off = 10'(off); win_data = 8'(val);
    @(negedge clk); win_we = 0;
  endtask

  task automatic commit(input int n, input int fill_before);
    int e = (n > 1020 - fill_before) ? 1020 - fill_before : n;
    commit_we = 1; commit_cnt = 10'(n);
    @(negedge clk); commit_we = 0;
    wp = (wp + e) % 1024;
  endtask

  task automatic pop1(input string req, input int exp);
    pop_ready = 1;
    check(req, pop_valid, 1);
    check(req, pop_data, exp);
    @(negedge clk); pop_ready = 0;
  endtask

  task automatic drain;
    pop_ready = 1;
    for (int i = 0; i < 2000 && !tx_empty; i++) @(negedge clk);
    pop_ready = 0;
  endtask

  task automatic t_reset;
    check("R1 ctrl", ctrl_rd, 0);
    check("R1 empty", tx_empty, 1);
    check("R1 space", space_avail, 1);
    check("R1 valid", pop_valid, 0);
  endtask

  task automatic t_stage;
    for (int i = 0; i < 4; i++) wr(i, 8'hA0 + i);
    check("R2 valid", pop_valid, 0);
    check("R2 fill", ctrl_rd[25:16], 0);
    commit(4, 0);
    check("R3 fill", ctrl_rd[25:16], 4);
    check("R7 wptr", ctrl_rd[9:0], wp);
    check("R9 notempty", tx_empty, 0);
    for (int i = 0; i < 4; i++) pop1("R10 data", 8'hA0 + i);
    check("R9 empty", tx_empty, 1);
  endtask

  task automatic t_offset;
    wr(2, 8'h33); wr(0, 8'h11); wr(1, 8'h22);
    commit(3, 0);
    check("R7 align", ctrl_rd[1:0], 3);
    check("R7 word", ctrl_rd, (3 << 16) | 7);
    pop1("R4 order", 8'h11);
    pop1("R4 order", 8'h22);
    pop1("R4 order", 8'h33);
  endtask

  task automatic t_thresh;
    lvl = 3'd0;
    commit(4, 0);
    check("R8 at4", space_avail, 1);
    commit(1, 4);
    check("R8 over4", space_avail, 0);
    lvl = 3'd1; #1;
    check("R8 lvl1", space_avail, 1);
    drain();
    lvl = 3'd5;
  endtask

  task automatic t_clamp;
    commit(1023, 0);
    check("R5 clamp", ctrl_rd[25:16], 1020);
    check("R3 wrap", ctrl_rd[9:0], wp);
    check("R8 full", space_avail, 0);
    commit(5, 1020);
    check("R5 full", ctrl_rd[25:16], 1020);
    check("R3 full wptr", ctrl_rd[9:0], wp);
    drain();
    check("R9 drained", tx_empty, 1);
  endtask

  task automatic t_ignore;
    for (int i = 0; i < 8; i++) wr(i, 8'h50 + i);
    commit(8, 0);
    wr(1016, 8'hEE);
    wr(1017, 8'hEF);
    pop1("R6 kept", 8'h50);
    pop1("R6 kept", 8'h51);
    drain();
  endtask

  task automatic t_simul;
    for (int i = 0; i < 3; i++) wr(i, i + 1);
    commit(3, 0);
    wr(0, 8'h77); wr(1, 8'h78);
    pop_ready = 1; commit_we = 1; commit_cnt = 10'd2;
    @(negedge clk); commit_we = 0; pop_ready = 0;
    wp = (wp + 2) % 1024;
    check("R11 fill", ctrl_rd[25:16], 4);
    pop1("R11 data", 2);
    pop1("R11 data", 3);
    pop1("R11 data", 8'h77);
    pop1("R11 data", 8'h78);
    check("R11 empty", tx_empty, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_stage();
        t_offset();
        t_thresh();
        t_clamp();
        t_ignore();
        t_simul();
      end
      begin
        repeat (100000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule